// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches virtual-to-physical translations for a requester that has already applied any segment base to its address. Every slot holds a virtual base, a span length in bytes and a physical page start. A lookup compares the incoming virtual address against every occupied slot at once, in the same cycle. It answers with either a hit and a physical address, or a miss that carries the faulting virtual address. Each slot covers a range of any length, not one fixed page.

New translations arrive through an insert port and go into an empty slot while one remains. After that they overwrite the slot used longest ago. The requester chooses, per lookup, whether a hit counts as a use. A single flush input empties the whole table. Duplicate or overlapping inserts are accepted without checks, and the most recently used matching slot decides the result.

Top module: `xlat_buf`

## Requirements
- R1: After reset no slot is occupied, so every lookup misses, and with `lk_valid` low both `lk_hit` and `lk_miss` are 0.
- R2: A slot matches address A when base <= A and A < base + span. The sum is computed one bit wider so that it never wraps, and a span of 0 never matches.
- R3: On a hit, `lk_paddr` equals the matching slot's page start bitwise-ORed with bits [11:0] of `lk_vaddr` zero-extended. The upper address bits take no part.
- R4: A valid lookup with no matching slot drives `lk_miss`=1, `lk_hit`=0 and `lk_fault_va`=`lk_vaddr` in the same cycle. `lk_hit` and `lk_miss` are never both 1.
- R5: While any slot is empty, an insert takes an empty slot, so up to 16 inserts (the default slot count) keep every earlier translation.
- R6: When every slot is occupied, an insert overwrites the least recently used slot.
- R7: An inserted translation becomes the most recently used one.
- R8: A hit with `lk_touch`=1 makes the matching slot most recently used at the clock edge. With `lk_touch`=0 the recency order stays as it was.
- R9: When several slots match, the result comes from the most recently used of them.
- R10: `flush_all` empties every slot at the next edge. An insert presented in the same cycle is discarded.
- R11: In a cycle with both an insert and a lookup, the lookup sees the table as it stood before the insert. A touching hit in that cycle is applied before the insert picks its victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Empty the whole table |
| ins_en | input | 1 | Insert a translation this cycle |
| ins_vbase | input | VA_W | Virtual base of the new translation |
| ins_span | input | VA_W | Span in bytes of the new translation |
| ins_pstart | input | PA_W | Physical page start of the new translation |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_touch | input | 1 | Count a hit as a use for recency |
| lk_hit | output | 1 | Lookup hit |
| lk_miss | output | 1 | Lookup miss fault |
| lk_paddr | output | PA_W | Translated physical address (0 unless hit) |
| lk_fault_va | output | VA_W | Faulting virtual address (0 unless miss) |

## Verification
An insert and a lookup can arrive in the same cycle, and that lookup may also be a touching hit on the slot that is about to be evicted. The bench fills the table and then, in one cycle, looks up the oldest slot with touch set while inserting a new translation over the same range. It expects the old physical address on the outputs in that cycle. Afterwards the second-oldest slot must be gone, and the shared range must now resolve to the new translation. A second case inserts a fresh region while looking it up in the same cycle, and expects a miss that cycle and a hit on the next one.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int DEF_ENTRIES = 16;
  localparam int DEF_VA_W    = 32;
  localparam int DEF_PA_W    = 32;
  localparam int DEF_OFS_W   = 12;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_HIT  = 2'd1,
    LK_MISS = 2'd2
  } lk_res_e;
endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
  parameter int N     = 16,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [VA_W-1:0]            wr_vbase,
  input  logic [VA_W-1:0]            wr_span,
  input  logic [PA_W-1:0]            wr_pstart,
  output logic [N-1:0][VA_W-1:0]     vbase,
  output logic [N-1:0][VA_W-1:0]     span,
  output logic [N-1:0][PA_W-1:0]     pstart,
  output logic [N-1:0]               valid
);
  logic write_lands;
  assign write_lands = wr_en && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbase  <= '0;
      span   <= '0;
      pstart <= '0;
      valid  <= '0;
    end else if (flush) begin
      valid <= '0;
    end else if (write_lands) begin
      vbase[wr_idx]  <= wr_vbase;
      span[wr_idx]   <= wr_span;
      pstart[wr_idx] <= wr_pstart;
      valid[wr_idx]  <= 1'b1;
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0)); // R10
  AST_WRITE_OCCUPIES: assert property (@(posedge clk) disable iff (!rst_n)
    write_lands |=> valid[$past(wr_idx)]); // R5
endmodule

// File: rtl/xlat_match_array.sv
module xlat_match_array #(
  parameter int N    = 16,
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0]         va,
  input  logic [N-1:0][VA_W-1:0]  vbase,
  input  logic [N-1:0][VA_W-1:0]  span,
  input  logic [N-1:0]            valid,
  output logic [N-1:0]            hit_vec
);
  function automatic logic span_covers(input logic [VA_W-1:0] b,
                                       input logic [VA_W-1:0] s,
                                       input logic [VA_W-1:0] a);
    logic [VA_W:0] lim;
    lim = {1'b0, b} + {1'b0, s};
    return (b <= a) && ({1'b0, a} < lim);
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit_vec[g] = valid[g] && span_covers(vbase[g], span[g], va);
  end
endmodule

// File: rtl/xlat_recency.sv
module xlat_recency #(
  parameter int N     = 16,
  parameter int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      hit_vec,
  input  logic [N-1:0]      valid,
  input  logic              touch_req,
  input  logic              ins_req,
  output logic              any_hit,
  output logic [IDX_W-1:0]  win_idx,
  output logic [IDX_W-1:0]  ins_slot
);
  typedef logic [N-1:0][IDX_W-1:0] age_vec_t;
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

  age_vec_t age, age_t, age_n;
  logic do_touch, any_free;
  logic [IDX_W-1:0] free_idx, lru_idx;

  function automatic age_vec_t promote(input age_vec_t a, input logic [IDX_W-1:0] idx);
    age_vec_t r;
    for (int i = 0; i < N; i++) begin
      if (IDX_W'(i) == idx)      r[i] = '0;
      else if (a[i] < a[idx])    r[i] = a[i] + 1'b1;
      else                       r[i] = a[i];
    end
    return r;
  endfunction

  always_comb begin
    logic found;
    logic [IDX_W-1:0] best;
    found   = 1'b0;
    best    = OLDEST;
    win_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i] && (!found || age[i] < best)) begin
        found   = 1'b1;
        best    = age[i];
        win_idx = IDX_W'(i);
      end
    end
    any_hit = found;
  end

  assign do_touch = touch_req && any_hit;
  assign age_t    = do_touch ? promote(age, win_idx) : age;

  always_comb begin
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) free_idx = IDX_W'(i);
    end
  end
  assign any_free = !(&valid);

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (age_t[i] == OLDEST) lru_idx = IDX_W'(i);
    end
  end

  assign ins_slot = any_free ? free_idx : lru_idx;
  assign age_n    = ins_req ? promote(age_t, ins_slot) : age_t;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
    end else begin
      age <= age_n;
    end
  end

  logic [N-1:0] rank_seen;
  always_comb begin
    rank_seen = '0;
    for (int i = 0; i < N; i++) rank_seen[age[i]] = 1'b1;
  end

  AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
    &rank_seen); // R7
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && any_free) |-> !valid[ins_slot]); // R5
  AST_EVICT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_req && !any_free && !do_touch) |-> (age[ins_slot] == OLDEST)); // R6
  AST_INSERT_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    ins_req |=> (age[$past(ins_slot)] == '0)); // R7
  AST_TOUCH_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    (do_touch && !ins_req) |=> (age[$past(win_idx)] == '0)); // R8
  AST_NO_TOUCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!touch_req && !ins_req) |=> $stable(age)); // R8
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
  import xlat_pkg::*;
#(
  parameter int N     = DEF_ENTRIES,
  parameter int VA_W  = DEF_VA_W,
  parameter int PA_W  = DEF_PA_W,
  parameter int OFS_W = DEF_OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_all,
  input  logic             ins_en,
  input  logic [VA_W-1:0]  ins_vbase,
  input  logic [VA_W-1:0]  ins_span,
  input  logic [PA_W-1:0]  ins_pstart,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic             lk_touch,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic [PA_W-1:0]  lk_paddr,
  output logic [VA_W-1:0]  lk_fault_va
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0][VA_W-1:0] vbase, span;
  logic [N-1:0][PA_W-1:0] pstart;
  logic [N-1:0]           valid, hit_vec;
  logic                   any_hit, ins_req, touch_req;
  logic [IDX_W-1:0]       win_idx, ins_slot;
  lk_res_e                lk_res;

  function automatic logic [PA_W-1:0] compose_pa(input logic [PA_W-1:0] ps,
                                                 input logic [VA_W-1:0] va);
    return ps | PA_W'(va[OFS_W-1:0]);
  endfunction

  assign ins_req   = ins_en && !flush_all;
  assign touch_req = lk_valid && lk_touch;

  xlat_entry_store #(.N(N), .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush_all),
    .wr_en(ins_req), .wr_idx(ins_slot),
    .wr_vbase(ins_vbase), .wr_span(ins_span), .wr_pstart(ins_pstart),
    .vbase(vbase), .span(span), .pstart(pstart), .valid(valid)
  );

  xlat_match_array #(.N(N), .VA_W(VA_W)) u_match (
    .va(lk_vaddr), .vbase(vbase), .span(span), .valid(valid), .hit_vec(hit_vec)
  );

  xlat_recency #(.N(N), .IDX_W(IDX_W)) u_rec (
    .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .valid(valid),
    .touch_req(touch_req), .ins_req(ins_req),
    .any_hit(any_hit), .win_idx(win_idx), .ins_slot(ins_slot)
  );

  always_comb begin
    if (!lk_valid)    lk_res = LK_IDLE;
    else if (any_hit) lk_res = LK_HIT;
    else              lk_res = LK_MISS;
  end

  assign lk_hit      = (lk_res == LK_HIT);
  assign lk_miss     = (lk_res == LK_MISS);
  assign lk_paddr    = lk_hit  ? compose_pa(pstart[win_idx], lk_vaddr) : '0;
  assign lk_fault_va = lk_miss ? lk_vaddr : '0;

  AST_HIT_MISS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> (lk_hit != lk_miss)); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_miss)); // R1
  AST_HIT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (valid[win_idx] && vbase[win_idx] <= lk_vaddr)); // R2
  AST_PA_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((lk_paddr[OFS_W-1:0] & lk_vaddr[OFS_W-1:0]) == lk_vaddr[OFS_W-1:0])); // R3
endmodule

// File: tb/xlat_buf_test.sv
module xlat_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush_all = 1'b0, ins_en = 1'b0, lk_valid = 1'b0, lk_touch = 1'b0;
  logic [31:0] ins_vbase = '0, ins_span = '0, ins_pstart = '0, lk_vaddr = '0;
  logic        lk_hit, lk_miss;
  logic [31:0] lk_paddr, lk_fault_va;

  int n_run = 0, n_fail = 0;
  logic        s_hit, s_miss;
  logic [31:0] s_pa, s_fva;

  always #4 clk = ~clk;

  xlat_buf uut (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .ins_en(ins_en), .ins_vbase(ins_vbase), .ins_span(ins_span), .ins_pstart(ins_pstart),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_touch(lk_touch),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr), .lk_fault_va(lk_fault_va)
  );

  function automatic logic [31:0] eb(input int i);
    return 32'h1000_0000 + (32'(i) << 16);
  endfunction
  function automatic logic [31:0] ep(input int i);
    return 32'h8000_0000 | (32'(i) << 20);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic lv, input logic [31:0] va, input logic tch,
                      input logic ie, input logic [31:0] b, input logic [31:0] s,
                      input logic [31:0] p, input logic fl);
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; lk_touch = tch;
    ins_en = ie; ins_vbase = b; ins_span = s; ins_pstart = p; flush_all = fl;
    #1;
    s_hit = lk_hit; s_miss = lk_miss; s_pa = lk_paddr; s_fva = lk_fault_va;
    @(posedge clk); #1;
    lk_valid = 0; lk_touch = 0; ins_en = 0; flush_all = 0;
  endtask

  task automatic ins(input logic [31:0] b, input logic [31:0] s, input logic [31:0] p);
    step(0, '0, 0, 1, b, s, p, 0);
  endtask
  task automatic flush();
    step(0, '0, 0, 0, '0, '0, '0, 1);
  endtask
  task automatic chk_hit(input string tag, input logic [31:0] va, input logic tch, input logic [31:0] exp_pa);
    step(1, va, tch, 0, '0, '0, '0, 0);
    check(s_hit && !s_miss && s_pa == exp_pa, tag, s_pa, exp_pa);
  endtask
  task automatic chk_miss(input string tag, input logic [31:0] va);
    step(1, va, 0, 0, '0, '0, '0, 0);
    check(s_miss && !s_hit && s_fva == va, tag, s_fva, va);
  endtask
  task automatic fill16();
    flush();
    for (int i = 0; i < 16; i++) ins(eb(i), 32'h1000, ep(i));
  endtask

  task automatic t_reset();
    #1;
    check(!lk_hit && !lk_miss, "R1 idle outputs quiet", {30'd0, lk_hit, lk_miss}, 32'd0);
    chk_miss("R1 empty table misses", 32'h1234_5678);
    chk_miss("R4 fault address reported", 32'hFFFF_0ABC);
  endtask

  task automatic t_range();
    flush();
    ins(32'h1000_0000, 32'h3000, 32'hA000_0100);
    chk_hit("R2 base address hits", 32'h1000_0000, 0, 32'hA000_0100);
    chk_hit("R3 offset ORed", 32'h1000_0011, 0, 32'hA000_0111);
    chk_hit("R3 upper bits ignored", 32'h1000_1000, 0, 32'hA000_0100);
    chk_hit("R2 last byte hits", 32'h1000_2FFF, 0, 32'hA000_0FFF);
    chk_miss("R2 end exclusive", 32'h1000_3000);
    chk_miss("R2 below base", 32'h0FFF_FFFF);
    ins(32'h5000_0000, 32'h0, 32'hB000_0000);
    chk_miss("R2 zero span", 32'h5000_0000);
    ins(32'hFFFF_F000, 32'h2000, 32'hC000_0000);
    chk_hit("R2 top of space", 32'hFFFF_FFFF, 0, 32'hC000_0FFF);
    chk_miss("R2 no wrap", 32'h0000_0000);
  endtask

  task automatic t_flush();
    flush();
    ins(32'h2000_0000, 32'h1000, 32'hD000_0000);
    chk_hit("R10 before flush", 32'h2000_0004, 0, 32'hD000_0004);
    step(0, '0, 0, 1, 32'h3000_0000, 32'h1000, 32'hE000_0000, 1);
    chk_miss("R10 flushed entry gone", 32'h2000_0004);
    chk_miss("R10 insert with flush discarded", 32'h3000_0004);
  endtask

  task automatic t_lru();
    fill16();
    for (int i = 0; i < 16; i++) chk_hit("R5 all sixteen kept", eb(i) + 32'h234, 0, ep(i) | 32'h234);
    chk_hit("R8 touch oldest", eb(0) + 32'h10, 1, ep(0) | 32'h10);
    ins(eb(16), 32'h1000, ep(16));
    chk_miss("R6 LRU evicted", eb(1));
    chk_hit("R8 touched survives", eb(0), 0, ep(0));
    chk_hit("R8 no-touch lookup", eb(2), 0, ep(2));
    ins(eb(17), 32'h1000, ep(17));
    chk_miss("R8 untouched oldest evicted", eb(2));
    chk_hit("R7 new insert survives", eb(16) + 32'h5, 0, ep(16) | 32'h5);
    chk_hit("R7 latest insert hits", eb(17), 0, ep(17));
  endtask

  task automatic t_overlap();
    flush();
    ins(32'h2000_0000, 32'h10000, 32'hC000_0000);
    ins(32'h2000_0000, 32'h1000,  32'hD000_0000);
    chk_hit("R9 younger wins", 32'h2000_0010, 0, 32'hD000_0010);
    chk_hit("R9 touch wide entry", 32'h2000_5000, 1, 32'hC000_0000);
    chk_hit("R9 promoted wins", 32'h2000_0010, 0, 32'hC000_0010);
  endtask

  task automatic t_same_cycle();
    fill16();
    step(1, eb(0) + 32'h44, 1, 1, eb(0), 32'h1000, 32'hF000_0000, 0);
    check(s_hit && s_pa == (ep(0) | 32'h44), "R11 lookup sees old table", s_pa, ep(0) | 32'h44);
    chk_miss("R11 victim chosen after touch", eb(1));
    chk_hit("R11 new overlapping entry wins", eb(0) + 32'h44, 0, 32'hF000_0044);
    step(1, 32'h7000_0008, 0, 1, 32'h7000_0000, 32'h1000, 32'h9900_0000, 0);
    check(s_miss && s_fva == 32'h7000_0008, "R11 same-cycle insert not visible", s_fva, 32'h7000_0008);
    chk_hit("R11 visible next cycle", 32'h7000_0008, 0, 32'h9900_0008);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_range();
    t_flush();
    t_lru();
    t_overlap();
    t_same_cycle();
    finish_run();
  end
endmodule